// File: doc/BRIEF.md
# Banked Host Register Window

This block is the host-facing register decoder of a network controller. The host addresses sixteen byte registers through a 4-bit address and moves 8- or 16-bit data. Addresses 0 to 7 always reach the same registers. Addresses 8 to 15 form a window whose contents depend on a bank-select field held in the configuration register at address 7. One bank holds node-identity and control bytes, one holds hash-table bytes, and one holds the buffer data port. The fourth code is reserved.

The configuration register also carries a fixed chip identifier, a power-enable bit, a read-only mirror of an external ready-polarity strap, an end-of-packet polarity bit and a byte-order bit. The buffer data port connects the host to two byte-wide memories. Host writes fill the transmit memory and host reads drain the receive memory, and each memory has its own auto-advancing pointer. In word mode the byte-order bit decides which lane carries the first byte of each pair. The network side reads the transmit memory and writes the receive memory through plain array ports.

A small access state machine tracks the kind of access made in the last cycle. It has three states: `ACC_IDLE` (no access), `ACC_WRITE` (a write was taken) and `ACC_READ` (a read was taken, so read data is presented). From any state the machine moves to `ACC_WRITE` when `host_wr` is high. Otherwise it moves to `ACC_READ` when `host_rd` is high, and otherwise to `ACC_IDLE`.

Top module: `hrw_window`

## Requirements
- R1: Addresses 0 to 6 are plain read/write byte registers that reset to 0, and address 7 is the configuration register. Both respond the same way under every bank-select value.
- R2: Configuration bits [3:2] select the bank seen at addresses 8 to 15. Code 00 is the node bank, 01 is the hash bank and 10 is the port bank. Each bank has separate storage.
- R3: With bank code 11, reads of addresses 8 to 15 return 0 and writes there change no storage.
- R4: The configuration register resets to bits [7:6] = CHIP_ID (default 2'b10, read-only), bit 5 = 1 and bits [3:0] = 0. Output `pwr_on` follows bit 5, where 1 means powered and 0 requests power-down.
- R5: Configuration bit 4 reads the level of `rdy_pol_pin`, and writes to that bit have no effect.
- R6: Configuration bit 1 sets the end-of-packet polarity. When it is 1, `eop_asserted` equals `eop_pin`; when it is 0, `eop_asserted` equals the inverse of `eop_pin`.
- R7: In the port bank, a write to address 8 stores data into the transmit memory at the transmit pointer. The pointer then advances by 1 in byte mode or by 2 in word mode, wrapping at BUF_DEPTH (default 64). `net_tx_byte` shows the byte at `net_tx_addr`.
- R8: In the port bank, a read of address 8 returns receive-memory data at the receive pointer. The pointer then advances by 1 in byte mode or by 2 in word mode, wrapping at BUF_DEPTH.
- R9: Configuration bit 0 sets the byte order. In word mode, a 1 puts the byte at the pointer on lane [15:8] and the next byte on lane [7:0], and a 0 reverses the two. Byte mode uses lane [7:0] only. Register reads return their byte on [7:0] with [15:8] = 0.
- R10: `host_rvalid` is high, and `host_rdata` holds the read data, in the cycle after a read is taken. Otherwise `host_rdata` is 0. When `host_wr` and `host_rd` are high together, the write is performed and the read is dropped, with no valid data and no receive-pointer advance.
- R11: In the port bank, a write to address 12 clears the transmit pointer when data bit 0 is 1 and clears the receive pointer when data bit 1 is 1. Reads of address 12 return 0.
- R12: The network side writes the receive memory with `net_rx_we`, `net_rx_addr` and `net_rx_byte`. A host port read of the same byte in the same cycle returns the byte's previous content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 16 | Host write data |
| word_mode | input | 1 | 1 = 16-bit host bus, 0 = 8-bit |
| rdy_pol_pin | input | 1 | Ready-polarity strap level |
| eop_pin | input | 1 | End-of-packet input pin |
| host_rdata | output | 16 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid |
| pwr_on | output | 1 | Power-enable bit |
| eop_asserted | output | 1 | End-of-packet after polarity correction |
| net_tx_addr | input | BUF_AW | Network-side transmit memory address |
| net_tx_byte | output | 8 | Transmit memory byte at net_tx_addr |
| net_rx_we | input | 1 | Network-side receive memory write |
| net_rx_addr | input | BUF_AW | Receive memory write address |
| net_rx_byte | input | 8 | Receive memory write data |

## Verification
A host port read and a network-side write to the same receive byte can fall in the same clock edge. The bench provokes this by raising `host_rd` at address 8 together with `net_rx_we` aimed at the byte under the receive pointer. The scoreboard expects the old byte, and the new byte must appear when the pointer is cleared and the memory is read again from the start. A second collision, `host_wr` and `host_rd` in the same cycle, is judged by the absence of `host_rvalid` and by the next read landing on the unchanged receive pointer.

// File: rtl/hrw_pkg.sv
package hrw_pkg;
    typedef enum logic [1:0] {
        BANK_NODE = 2'b00,
        BANK_HASH = 2'b01,
        BANK_PORT = 2'b10,
        BANK_RSVD = 2'b11
    } bank_e;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_READ  = 2'b10
    } acc_e;

    // Field order is the bit order of the configuration byte, MSB first.
    typedef struct packed {
        logic [1:0] id;
        logic       pwr_on;
        logic       rdy_pol;
        bank_e      bank;
        logic       eop_hi;
        logic       hi_first;
    } cfg_t;

    localparam int unsigned BANK_CNT  = 3;
    localparam int unsigned WIN_REGS  = 8;
endpackage

// File: rtl/hrw_reg_file.sv
module hrw_reg_file #(
    parameter int unsigned N  = 8,
    localparam int unsigned AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wbyte,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rbyte
);
    logic [7:0] regs [N];

    for (genvar i = 0; i < N; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[i] <= 8'h00;
            end else if (we && (waddr == AW'(i))) begin
                regs[i] <= wbyte;
            end
        end
    end

    assign rbyte = regs[raddr];
endmodule

// File: rtl/hrw_cfg_reg.sv
module hrw_cfg_reg
    import hrw_pkg::*;
#(
    parameter logic [1:0] CHIP_ID = 2'b10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic       w_pwr,
    input  logic [1:0] w_bank,
    input  logic       w_eop,
    input  logic       w_hi,
    input  logic       rdy_pin,
    output cfg_t       cfg
);
    logic  pwr_q;
    bank_e bank_q;
    logic  eop_q;
    logic  hi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q  <= 1'b1;
            bank_q <= BANK_NODE;
            eop_q  <= 1'b0;
            hi_q   <= 1'b0;
        end else if (we) begin
            pwr_q  <= w_pwr;
            bank_q <= bank_e'(w_bank);
            eop_q  <= w_eop;
            hi_q   <= w_hi;
        end
    end

    always_comb begin
        cfg.id       = CHIP_ID;
        cfg.pwr_on   = pwr_q;
        cfg.rdy_pol  = rdy_pin;
        cfg.bank     = bank_q;
        cfg.eop_hi   = eop_q;
        cfg.hi_first = hi_q;
    end

    // R4: configuration holds its value unless written
    a_r4_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(pwr_q) && $stable(bank_q) && $stable(eop_q) && $stable(hi_q)));
endmodule

// File: rtl/hrw_buf_port.sv
module hrw_buf_port #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic          word_mode,
    input  logic          hi_first,
    input  logic [15:0]   wdata,
    input  logic          tx_clr,
    input  logic          rx_clr,
    output logic [15:0]   rd_word,
    input  logic [AW-1:0] net_tx_addr,
    output logic [7:0]    net_tx_byte,
    input  logic          net_rx_we,
    input  logic [AW-1:0] net_rx_addr,
    input  logic [7:0]    net_rx_byte
);
    logic [7:0]    tx_mem [DEPTH];
    logic [7:0]    rx_mem [DEPTH];
    logic [AW-1:0] tx_ptr, rx_ptr;
    logic [AW-1:0] tx_nxt, rx_nxt;
    logic [AW-1:0] step;
    logic [7:0]    first_b, second_b;
    logic [7:0]    rb0, rb1;

    assign step   = word_mode ? AW'(2) : AW'(1);
    assign tx_nxt = tx_ptr + AW'(1);
    assign rx_nxt = rx_ptr + AW'(1);

    // lane selection: which host lane carries the byte at the pointer
    assign first_b  = (word_mode && hi_first) ? wdata[15:8] : wdata[7:0];
    assign second_b = hi_first ? wdata[7:0] : wdata[15:8];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_ptr <= '0;
        end else if (tx_clr) begin
            tx_ptr <= '0;
        end else if (host_wr) begin
            tx_ptr <= tx_ptr + step;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_ptr <= '0;
        end else if (rx_clr) begin
            rx_ptr <= '0;
        end else if (host_rd) begin
            rx_ptr <= rx_ptr + step;
        end
    end

    always_ff @(posedge clk) begin
        if (host_wr) begin
            tx_mem[tx_ptr] <= first_b;
            if (word_mode) begin
                tx_mem[tx_nxt] <= second_b;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (net_rx_we) begin
            rx_mem[net_rx_addr] <= net_rx_byte;
        end
    end

    assign rb0 = rx_mem[rx_ptr];
    assign rb1 = rx_mem[rx_nxt];

    always_comb begin
        if (!word_mode) begin
            rd_word = {8'h00, rb0};
        end else if (hi_first) begin
            rd_word = {rb0, rb1};
        end else begin
            rd_word = {rb1, rb0};
        end
    end

    assign net_tx_byte = tx_mem[net_tx_addr];

    // R7: transmit pointer advances by the access size
    a_r7_tx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !tx_clr) |=> (tx_ptr == $past(tx_ptr + step)));
    // R8: receive pointer advances by the access size
    a_r8_rx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !rx_clr) |=> (rx_ptr == $past(rx_ptr + step)));
    // R10: receive pointer holds without a port read
    a_r10_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_rd && !rx_clr) |=> $stable(rx_ptr));
    // R11: clear brings the pointers to zero
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_clr || rx_clr) |=> ((!$past(tx_clr) || tx_ptr == '0) && (!$past(rx_clr) || rx_ptr == '0)));
endmodule

// File: rtl/hrw_window.sv
module hrw_window
    import hrw_pkg::*;
#(
    parameter logic [1:0]  CHIP_ID   = 2'b10,
    parameter int unsigned BUF_DEPTH = 64,
    localparam int unsigned BUF_AW   = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [3:0]        host_addr,
    input  logic [15:0]       host_wdata,
    input  logic              word_mode,
    input  logic              rdy_pol_pin,
    input  logic              eop_pin,
    output logic [15:0]       host_rdata,
    output logic              host_rvalid,
    output logic              pwr_on,
    output logic              eop_asserted,
    input  logic [BUF_AW-1:0] net_tx_addr,
    output logic [7:0]        net_tx_byte,
    input  logic              net_rx_we,
    input  logic [BUF_AW-1:0] net_rx_addr,
    input  logic [7:0]        net_rx_byte
);
    localparam int unsigned IDX_W   = $clog2(WIN_REGS);
    localparam logic [IDX_W-1:0] IDX_CFG  = IDX_W'(7);
    localparam logic [IDX_W-1:0] IDX_PORT = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_PCLR = IDX_W'(4);

    acc_e             state_q, state_d;
    cfg_t             cfg;
    logic [IDX_W-1:0] idx;
    logic             upper;
    logic             rd_take;
    logic             lo_we, cfg_we;
    logic [BANK_CNT-1:0] bank_we;
    logic [7:0]       lo_rd;
    logic [7:0]       bank_rd [BANK_CNT];
    logic             port_wr, port_rd, pclr_we;
    logic [15:0]      port_word;
    logic [15:0]      rd_c, rdata_q;

    assign idx     = host_addr[IDX_W-1:0];
    assign upper   = host_addr[3];
    assign rd_take = host_rd && !host_wr;

    // ---------------- fixed lower half ----------------
    assign lo_we  = host_wr && !upper && (idx != IDX_CFG);
    assign cfg_we = host_wr && !upper && (idx == IDX_CFG);

    hrw_reg_file #(.N(WIN_REGS)) u_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (lo_we),
        .waddr (idx),
        .wbyte (host_wdata[7:0]),
        .raddr (idx),
        .rbyte (lo_rd)
    );

    hrw_cfg_reg #(.CHIP_ID(CHIP_ID)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .w_pwr   (host_wdata[5]),
        .w_bank  (host_wdata[3:2]),
        .w_eop   (host_wdata[1]),
        .w_hi    (host_wdata[0]),
        .rdy_pin (rdy_pol_pin),
        .cfg     (cfg)
    );

    // ---------------- banked upper half ----------------
    for (genvar g = 0; g < BANK_CNT; g++) begin : g_bank
        localparam bit IS_PORT = (g == int'(BANK_PORT));
        logic special;
        assign special = IS_PORT && ((idx == IDX_PORT) || (idx == IDX_PCLR));
        assign bank_we[g] = host_wr && upper && (cfg.bank == bank_e'(g)) && !special;

        hrw_reg_file #(.N(WIN_REGS)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we[g]),
            .waddr (idx),
            .wbyte (host_wdata[7:0]),
            .raddr (idx),
            .rbyte (bank_rd[g])
        );
    end

    assign port_wr = host_wr && upper && (cfg.bank == BANK_PORT) && (idx == IDX_PORT);
    assign port_rd = rd_take && upper && (cfg.bank == BANK_PORT) && (idx == IDX_PORT);
    assign pclr_we = host_wr && upper && (cfg.bank == BANK_PORT) && (idx == IDX_PCLR);

    hrw_buf_port #(.DEPTH(BUF_DEPTH)) u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wr     (port_wr),
        .host_rd     (port_rd),
        .word_mode   (word_mode),
        .hi_first    (cfg.hi_first),
        .wdata       (host_wdata),
        .tx_clr      (pclr_we && host_wdata[0]),
        .rx_clr      (pclr_we && host_wdata[1]),
        .rd_word     (port_word),
        .net_tx_addr (net_tx_addr),
        .net_tx_byte (net_tx_byte),
        .net_rx_we   (net_rx_we),
        .net_rx_addr (net_rx_addr),
        .net_rx_byte (net_rx_byte)
    );

    // ---------------- read multiplexer ----------------
    always_comb begin
        rd_c = '0;
        if (!upper) begin
            rd_c = (idx == IDX_CFG) ? {8'h00, cfg} : {8'h00, lo_rd};
        end else begin
            unique case (cfg.bank)
                BANK_NODE: rd_c = {8'h00, bank_rd[0]};
                BANK_HASH: rd_c = {8'h00, bank_rd[1]};
                BANK_PORT: begin
                    if (idx == IDX_PORT)      rd_c = port_word;
                    else if (idx == IDX_PCLR) rd_c = '0;
                    else                      rd_c = {8'h00, bank_rd[2]};
                end
                BANK_RSVD: rd_c = '0;
            endcase
        end
    end

    // ---------------- access state machine ----------------
    always_comb begin
        state_d = ACC_IDLE;
        if (host_wr)      state_d = ACC_WRITE;
        else if (host_rd) state_d = ACC_READ;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ACC_READ) rdata_q <= rd_c;
        end
    end

    always_comb begin
        unique case (state_q)
            ACC_IDLE:  begin host_rvalid = 1'b0; host_rdata = '0;      end
            ACC_WRITE: begin host_rvalid = 1'b0; host_rdata = '0;      end
            ACC_READ:  begin host_rvalid = 1'b1; host_rdata = rdata_q; end
            default:   begin host_rvalid = 1'b0; host_rdata = '0;      end
        endcase
    end

    assign pwr_on       = cfg.pwr_on;
    assign eop_asserted = cfg.eop_hi ? eop_pin : !eop_pin;

    // R10: a taken read yields valid data next cycle
    a_r10_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_take |=> host_rvalid);
    // R10: no read taken, no valid data, and data is zero
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_take |=> (!host_rvalid && host_rdata == 16'h0000));
    // R3: reserved bank reads return zero
    a_r3_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take && upper && cfg.bank == BANK_RSVD) |=> (host_rdata == 16'h0000));
    // R3: reserved bank writes touch no banked storage
    a_r3_rsvd_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.bank == BANK_RSVD) |-> (bank_we == '0 && !port_wr && !pclr_we));
    // R9: register reads keep the upper lane at zero
    a_r9_reg_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take && !upper) |=> (host_rdata[15:8] == 8'h00));
endmodule

// File: tb/tb_hrw_window.sv
module tb_hrw_window;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;
    localparam int AW = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0, host_rd = 1'b0;
    logic [3:0]    host_addr = '0;
    logic [15:0]   host_wdata = '0;
    logic          word_mode = 1'b0;
    logic          rdy_pol_pin = 1'b1;
    logic          eop_pin = 1'b0;
    logic [15:0]   host_rdata;
    logic          host_rvalid;
    logic          pwr_on, eop_asserted;
    logic [AW-1:0] net_tx_addr = '0;
    logic [7:0]    net_tx_byte;
    logic          net_rx_we = 1'b0;
    logic [AW-1:0] net_rx_addr = '0;
    logic [7:0]    net_rx_byte = '0;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hrw_window #(.CHIP_ID(2'b10), .BUF_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .word_mode(word_mode),
        .rdy_pol_pin(rdy_pol_pin), .eop_pin(eop_pin), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .pwr_on(pwr_on), .eop_asserted(eop_asserted),
        .net_tx_addr(net_tx_addr), .net_tx_byte(net_tx_byte), .net_rx_we(net_rx_we),
        .net_rx_addr(net_rx_addr), .net_rx_byte(net_rx_byte)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] cfgv(input logic pwr, input logic [1:0] bank,
                                         input logic eop, input logic hi);
        return {8'h00, 2'b10, pwr, rdy_pol_pin, bank, eop, hi};
    endfunction

    // monitor: pops expected read data as the design presents it
    always @(negedge clk) begin
        if (rst_n && host_rvalid) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R10 unexpected rvalid actual=%h expected=none", host_rdata);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, host_rdata, e);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [15:0] e, input string tag);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic tx_at(input int a, input logic [7:0] e, input string tag);
        net_tx_addr = AW'(a);
        #1;
        chk(tag, {8'h00, net_tx_byte}, {8'h00, e});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 R10 reset state
        chk("R10 rvalid idle", {15'h0, host_rvalid}, 16'h0);
        chk("R10 rdata idle", host_rdata, 16'h0);
        chk("R4 pwr_on reset", {15'h0, pwr_on}, 16'h1);
        rd(4'd7, cfgv(1, 2'b00, 0, 0), "R4 cfg reset");
        // R5 strap mirror, writes to bit 4 ignored
        rdy_pol_pin = 1'b0;
        wr(4'd7, 16'h0030);
        rd(4'd7, cfgv(1, 2'b00, 0, 0), "R5 strap low");
        rdy_pol_pin = 1'b1;
        rd(4'd7, cfgv(1, 2'b00, 0, 0), "R5 strap high");
        // R4 power-down request
        wr(4'd7, 16'h0000);
        chk("R4 pwr_on cleared", {15'h0, pwr_on}, 16'h0);
        wr(4'd7, 16'h0020);
        chk("R4 pwr_on set", {15'h0, pwr_on}, 16'h1);
        // R1 fixed lower registers
        wr(4'd0, 16'h0011);
        wr(4'd6, 16'h0066);
        rd(4'd0, 16'h0011, "R1 addr0");
        rd(4'd6, 16'h0066, "R1 addr6");
        // R2 banks
        wr(4'd8, 16'h00A8);
        wr(4'd9, 16'h0039);
        wr(4'd7, 16'h0024);
        wr(4'd8, 16'h005C);
        rd(4'd8, 16'h005C, "R2 hash bank");
        rd(4'd0, 16'h0011, "R1 addr0 in hash bank");
        wr(4'd7, 16'h0020);
        rd(4'd8, 16'h00A8, "R2 node bank kept");
        // R3 reserved bank
        wr(4'd7, 16'h002C);
        wr(4'd9, 16'h00FF);
        rd(4'd9, 16'h0000, "R3 reserved read");
        rd(4'd6, 16'h0066, "R1 addr6 in reserved bank");
        wr(4'd7, 16'h0020);
        rd(4'd9, 16'h0039, "R3 node byte untouched");
        wr(4'd7, 16'h0024);
        rd(4'd9, 16'h0000, "R3 hash byte untouched");
        // R6 end-of-packet polarity
        wr(4'd7, 16'h0020);
        eop_pin = 1'b0; #1;
        chk("R6 active-low asserted", {15'h0, eop_asserted}, 16'h1);
        eop_pin = 1'b1; #1;
        chk("R6 active-low idle", {15'h0, eop_asserted}, 16'h0);
        wr(4'd7, 16'h0022);
        chk("R6 active-high asserted", {15'h0, eop_asserted}, 16'h1);
        eop_pin = 1'b0;
        // R7 R9 transmit side
        wr(4'd7, 16'h0028);
        word_mode = 1'b0;
        wr(4'd8, 16'h9941);
        wr(4'd8, 16'h0042);
        tx_at(0, 8'h41, "R7 tx byte0");
        tx_at(1, 8'h42, "R7 tx byte1");
        word_mode = 1'b1;
        wr(4'd8, 16'hBBAA);
        tx_at(2, 8'hAA, "R9 low-first byte2");
        tx_at(3, 8'hBB, "R9 low-first byte3");
        wr(4'd7, 16'h0029);
        wr(4'd8, 16'hCCDD);
        tx_at(4, 8'hCC, "R9 high-first byte4");
        tx_at(5, 8'hDD, "R9 high-first byte5");
        rd(4'd7, cfgv(1, 2'b10, 0, 1), "R9 register read word mode");
        // R11 R7 clear and wrap
        word_mode = 1'b0;
        wr(4'd12, 16'h0001);
        rd(4'd12, 16'h0000, "R11 clear reg reads zero");
        for (int i = 0; i < DEPTH; i++) wr(4'd8, 16'(i + 1));
        tx_at(0, 8'h01, "R11 first after clear");
        wr(4'd8, 16'h00EE);
        tx_at(0, 8'hEE, "R7 wrap byte0");
        tx_at(1, 8'h02, "R7 wrap byte1 kept");
        // R8 R9 receive side
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            net_rx_we = 1'b1; net_rx_addr = AW'(i); net_rx_byte = 8'(8'h80 + i);
        end
        @(negedge clk);
        net_rx_we = 1'b0;
        rd(4'd8, 16'h0080, "R8 rx byte0");
        rd(4'd8, 16'h0081, "R8 rx byte1");
        word_mode = 1'b1;
        rd(4'd8, 16'h8283, "R9 rx high-first");
        wr(4'd7, 16'h0028);
        rd(4'd8, 16'h8584, "R9 rx low-first");
        word_mode = 1'b0;
        // R10 write and read together: read dropped
        @(negedge clk);
        host_wr = 1'b1; host_rd = 1'b1; host_addr = 4'd8; host_wdata = 16'h0055;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        chk("R10 no rvalid on write+read", {15'h0, host_rvalid}, 16'h0);
        tx_at(1, 8'h55, "R10 write taken");
        // R12 collision: old byte returned, rx pointer unmoved by R10 case
        @(negedge clk);
        host_rd = 1'b1; host_addr = 4'd8;
        net_rx_we = 1'b1; net_rx_addr = AW'(6); net_rx_byte = 8'h99;
        exp_q.push_back(16'h0086); tag_q.push_back("R12 old byte on collision");
        @(negedge clk);
        host_rd = 1'b0; net_rx_we = 1'b0;
        rd(4'd8, 16'h0087, "R8 rx byte7");
        wr(4'd12, 16'h0002);
        rd(4'd8, 16'h0080, "R11 rx cleared");
        for (int i = 1; i < 7; i++)
            rd(4'd8, (i == 6) ? 16'h0099 : 16'(16'h0080 + i), "R12 new byte stored");
        repeat (3) @(negedge clk);
        chk("R10 scoreboard drained", 16'(exp_q.size()), 16'h0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule